// File: doc/BRIEF.md
# Pipelined Signed Integer Divider

This block divides a signed two's complement dividend by a narrower signed two's complement divisor and returns a signed quotient of the dividend's width. One new operation enters every clock. The pipeline always works on whatever the two operand registers currently hold. Each operand register has its own active-low load enable. A divisor loaded once can therefore stay in place while a stream of dividends passes through it, which gives division by a constant.

Each quotient leaves the block with two flags. One marks a zero divisor. The other marks a division whose remainder was not zero. The quotient and both flags sit behind a registered, active-low output enable, and a qualifier output tells whether they are being driven. The core is a non-restoring array. It works on operand magnitudes and splits the quotient bits evenly over a parameterised number of stages. A sign-fix register and an output register follow the array, so a result appears 19 clocks after its operands are captured at the default parameters.

Top module: `sdiv_pipe`

## Requirements
- R1: The dividend register captures `dvd_in` on a rising edge only while `dvd_ld_n` is 0, and the divisor register captures `dvs_in` only while `dvs_ld_n` is 0. A register whose enable is 1 keeps its previous content, and later results use the held value.
- R2: The result of the operands held after rising edge k appears on the outputs after rising edge k+19. A different result can appear after every edge.
- R3: The quotient is the signed quotient truncated toward zero, for example -100 / 7 gives 0xFFFFFFF2. When the dividend's magnitude is below the divisor's, the quotient is 0.
- R4: Dividing 0x80000000 by 0xFFFF (-1) returns 0x80000000 with `inexact` low.
- R5: `inexact` is 1 exactly when the divisor is nonzero and the remainder is nonzero. It is 0 whenever `dz` is 1.
- R6: `dz` is 1 exactly when the divisor used was 0, whatever the dividend. The quotient in that case is undefined.
- R7: `out_vld` after an edge equals the inverse of `oe_n` sampled at that edge. While `out_vld` is 0, `quo`, `dz` and `inexact` read 0.
- R8: Synchronous reset clears all outputs. Until both operand registers have been loaded after reset, every result reads as a quotient of 0 with both flags at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| dvd_in | input | DW | Dividend, two's complement |
| dvd_ld_n | input | 1 | Dividend register load enable, active low |
| dvs_in | input | VW | Divisor, two's complement |
| dvs_ld_n | input | 1 | Divisor register load enable, active low |
| oe_n | input | 1 | Output enable, active low, registered |
| quo | output | DW | Quotient, 0 while outputs are disabled |
| dz | output | 1 | Divisor was zero for this quotient |
| inexact | output | 1 | Division left a nonzero remainder |
| out_vld | output | 1 | Outputs are being driven |

## Verification
The bench builds the block at its defaults: a 32-bit dividend, a 16-bit divisor and 16 stages that each retire two quotient bits. These widths bring the most negative dividend, the most negative divisor and the one overflow pair into reach, alongside ordinary mixed-sign operands. A scoreboard predicts every output cycle from the operand registers the bench models 19 edges earlier. It therefore follows back-to-back random traffic, held divisors, zero divisors and output-enable toggling while the pipeline stays full.

// File: rtl/sdiv_pipe.sv
module sdiv_pipe #(
  parameter int DW   = 32,
  parameter int VW   = 16,
  parameter int NSTG = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] dvd_in,
  input  logic          dvd_ld_n,
  input  logic [VW-1:0] dvs_in,
  input  logic          dvs_ld_n,
  input  logic          oe_n,
  output logic [DW-1:0] quo,
  output logic          dz,
  output logic          inexact,
  output logic          out_vld
);
  localparam int BPS = DW / NSTG;
  localparam int RW  = VW + 3;

  function automatic logic [RW+DW-1:0] nr_step(input logic signed [RW-1:0] r,
                                               input logic [DW-1:0] sh,
                                               input logic [VW-1:0] d);
    logic signed [RW-1:0] rr, t, dx;
    logic [DW-1:0] ss;
    rr = r;
    ss = sh;
    dx = $signed({{(RW-VW){1'b0}}, d});
    for (int i = 0; i < BPS; i++) begin
      t  = {rr[RW-2:0], ss[DW-1]};
      rr = rr[RW-1] ? t + dx : t - dx;
      ss = {ss[DW-2:0], ~rr[RW-1]};
    end
    return {rr, ss};
  endfunction

  logic [DW-1:0] dvd_r;
  logic [VW-1:0] dvs_r;
  logic          dvd_seen, dvs_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      dvd_r    <= '0;
      dvs_r    <= '0;
      dvd_seen <= 1'b0;
      dvs_seen <= 1'b0;
    end else begin
      if (!dvd_ld_n) begin
        dvd_r    <= dvd_in;
        dvd_seen <= 1'b1;
      end
      if (!dvs_ld_n) begin
        dvs_r    <= dvs_in;
        dvs_seen <= 1'b1;
      end
    end
  end

  logic signed [RW-1:0] st_rem  [0:NSTG];
  logic [DW-1:0]        st_sh   [0:NSTG];
  logic [VW-1:0]        st_d    [0:NSTG];
  logic                 st_neg  [0:NSTG];
  logic                 st_dz   [0:NSTG];
  logic                 st_live [0:NSTG];

  always_ff @(posedge clk) begin
    if (rst) begin
      st_rem[0]  <= '0;
      st_sh[0]   <= '0;
      st_d[0]    <= '0;
      st_neg[0]  <= 1'b0;
      st_dz[0]   <= 1'b0;
      st_live[0] <= 1'b0;
    end else begin
      st_rem[0]  <= '0;
      st_sh[0]   <= dvd_r[DW-1] ? -dvd_r : dvd_r;
      st_d[0]    <= dvs_r[VW-1] ? -dvs_r : dvs_r;
      st_neg[0]  <= dvd_r[DW-1] ^ dvs_r[VW-1];
      st_dz[0]   <= (dvs_r == '0);
      st_live[0] <= dvd_seen & dvs_seen;
    end
  end

  for (genvar s = 1; s <= NSTG; s++) begin : g_stg
    logic [RW+DW-1:0] nx;
    assign nx = nr_step(st_rem[s-1], st_sh[s-1], st_d[s-1]);
    always_ff @(posedge clk) begin
      if (rst) begin
        st_rem[s]  <= '0;
        st_sh[s]   <= '0;
        st_d[s]    <= '0;
        st_neg[s]  <= 1'b0;
        st_dz[s]   <= 1'b0;
        st_live[s] <= 1'b0;
      end else begin
        st_rem[s]  <= nx[RW+DW-1:DW];
        st_sh[s]   <= nx[DW-1:0];
        st_d[s]    <= st_d[s-1];
        st_neg[s]  <= st_neg[s-1];
        st_dz[s]   <= st_dz[s-1];
        st_live[s] <= st_live[s-1];
      end
    end
  end

  logic signed [RW-1:0] rem_fix;
  logic                 rem_nz;
  assign rem_fix = st_rem[NSTG] + $signed({{(RW-VW){1'b0}}, st_d[NSTG]});
  assign rem_nz  = st_rem[NSTG][RW-1] ? (rem_fix != '0) : (st_rem[NSTG] != '0);

  logic [DW-1:0] p_q, o_q;
  logic          p_dz, p_rm, p_live, o_dz, o_rm;

  always_ff @(posedge clk) begin
    if (rst) begin
      p_q    <= '0;
      p_dz   <= 1'b0;
      p_rm   <= 1'b0;
      p_live <= 1'b0;
      o_q    <= '0;
      o_dz   <= 1'b0;
      o_rm   <= 1'b0;
      out_vld <= 1'b0;
    end else begin
      p_q    <= st_neg[NSTG] ? -st_sh[NSTG] : st_sh[NSTG];
      p_dz   <= st_dz[NSTG];
      p_rm   <= rem_nz & ~st_dz[NSTG];
      p_live <= st_live[NSTG];
      o_q    <= p_live ? p_q : '0;
      o_dz   <= p_live & p_dz;
      o_rm   <= p_live & p_rm;
      out_vld <= ~oe_n;
    end
  end

  assign quo     = out_vld ? o_q : '0;
  assign dz      = out_vld & o_dz;
  assign inexact = out_vld & o_rm;
endmodule

// File: rtl/sdiv_pipe_chk.sv
module sdiv_pipe_chk #(
  parameter int DW = 32,
  parameter int VW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          oe_n,
  input logic          dvd_ld_n,
  input logic          dvs_ld_n,
  input logic [DW-1:0] dvd_r,
  input logic [VW-1:0] dvs_r,
  input logic [DW-1:0] quo,
  input logic          dz,
  input logic          inexact,
  input logic          out_vld
);
  p_hold_dividend_r1: assert property (@(posedge clk) disable iff (rst)
    dvd_ld_n |=> $stable(dvd_r));

  p_hold_divisor_r1: assert property (@(posedge clk) disable iff (rst)
    dvs_ld_n |=> $stable(dvs_r));

  p_flag_excl_r5: assert property (@(posedge clk) disable iff (rst)
    dz |-> !inexact);

  p_oe_late_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (out_vld == !$past(oe_n)));

  p_gated_r7: assert property (@(posedge clk) disable iff (rst)
    !out_vld |-> (quo == '0 && !dz && !inexact));

  p_reset_clear_r8: assert property (@(posedge clk)
    $fell(rst) |-> (quo == '0 && !dz && !inexact && !out_vld));
endmodule

bind sdiv_pipe sdiv_pipe_chk #(.DW(DW), .VW(VW)) u_chk (
  .clk(clk), .rst(rst), .oe_n(oe_n), .dvd_ld_n(dvd_ld_n), .dvs_ld_n(dvs_ld_n),
  .dvd_r(dvd_r), .dvs_r(dvs_r), .quo(quo), .dz(dz), .inexact(inexact),
  .out_vld(out_vld)
);

// File: tb/tb_sdiv_pipe.sv
`timescale 1ns/1ps
module tb_sdiv_pipe;
  localparam int LAT = 19;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] dvd_in = '0;
  logic        dvd_ld_n = 1'b1;
  logic [15:0] dvs_in = '0;
  logic        dvs_ld_n = 1'b1;
  logic        oe_n = 1'b1;
  logic [31:0] quo;
  logic        dz, inexact, out_vld;

  always #2 clk = ~clk;

  sdiv_pipe dut (
    .clk(clk), .rst(rst), .dvd_in(dvd_in), .dvd_ld_n(dvd_ld_n),
    .dvs_in(dvs_in), .dvs_ld_n(dvs_ld_n), .oe_n(oe_n),
    .quo(quo), .dz(dz), .inexact(inexact), .out_vld(out_vld)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference model of the operand registers and the result pipeline
  logic [31:0] ma, mb_ext;
  logic [15:0] mb;
  bit          sa, sb, mv;
  logic [31:0] ex_q  [0:LAT];
  bit          ex_dz [0:LAT];
  bit          ex_rm [0:LAT];

  always @(posedge clk) begin
    longint na, nb;
    if (rst) begin
      ma = '0; mb = '0; sa = 0; sb = 0; mv = 0;
      for (int i = 0; i <= LAT; i++) begin ex_q[i] = '0; ex_dz[i] = 0; ex_rm[i] = 0; end
    end else begin
      if (!dvd_ld_n) begin ma = dvd_in; sa = 1; end
      if (!dvs_ld_n) begin mb = dvs_in; sb = 1; end
      mv = !oe_n;
      for (int i = LAT; i > 0; i--) begin
        ex_q[i] = ex_q[i-1]; ex_dz[i] = ex_dz[i-1]; ex_rm[i] = ex_rm[i-1];
      end
      ex_q[0] = '0; ex_dz[0] = 0; ex_rm[0] = 0;
      if (sa && sb) begin
        if (mb == '0) ex_dz[0] = 1;
        else begin
          na = $signed(ma);
          nb = $signed(mb);
          ex_q[0]  = 32'(na / nb);
          ex_rm[0] = (na % nb) != 0;
        end
      end
    end
  end

  // scoreboard: every output cycle against the model (R2, R3, R5, R6, R7)
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R7 out_vld", {31'b0, out_vld}, {31'b0, mv});
      chk("R6 dz", {31'b0, dz}, {31'b0, mv && ex_dz[LAT]});
      chk("R5 inexact", {31'b0, inexact}, {31'b0, mv && ex_rm[LAT]});
      if (!(mv && ex_dz[LAT]))
        chk("R2/R3 quotient", quo, mv ? ex_q[LAT] : 32'h0);
    end
  end

  // a, b, expected quotient, dz, inexact
  localparam logic [81:0] VEC [13] = '{
    {32'd100,        16'd7,      32'h0000000E, 1'b0, 1'b1},
    {32'hFFFFFF9C,   16'd7,      32'hFFFFFFF2, 1'b0, 1'b1},
    {32'd100,        16'hFFF9,   32'hFFFFFFF2, 1'b0, 1'b1},
    {32'hFFFFFF9C,   16'hFFF9,   32'h0000000E, 1'b0, 1'b1},
    {32'h80000000,   16'hFFFF,   32'h80000000, 1'b0, 1'b0},
    {32'h7FFFFFFF,   16'h0001,   32'h7FFFFFFF, 1'b0, 1'b0},
    {32'd5,          16'd9,      32'h00000000, 1'b0, 1'b1},
    {32'd42,         16'h0000,   32'h00000000, 1'b1, 1'b0},
    {32'h80000000,   16'h8000,   32'h00010000, 1'b0, 1'b0},
    {32'h7FFFFFFF,   16'h7FFF,   32'h00010002, 1'b0, 1'b1},
    {32'hFFFFFFFF,   16'h0002,   32'h00000000, 1'b0, 1'b1},
    {32'd1000,       16'hFC18,   32'hFFFFFFFF, 1'b0, 1'b0},
    {32'h00000000,   16'h8000,   32'h00000000, 1'b0, 1'b0}
  };

  task automatic finish_run;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8: reset state
    chk("R8 reset quo", quo, 32'h0);
    chk("R8 reset flags", {30'b0, dz, inexact}, 32'h0);
    chk("R8 reset vld", {31'b0, out_vld}, 32'h0);

    // R8: only dividend loaded, divisor register still 0 -> no dz
    oe_n = 1'b0; dvd_in = 32'd77; dvd_ld_n = 1'b0;
    @(negedge clk); dvd_ld_n = 1'b1;
    repeat (LAT + 4) @(negedge clk);
    chk("R8 unarmed dz", {31'b0, dz}, 32'h0);
    chk("R8 unarmed quo", quo, 32'h0);

    // R7: enable acts one edge late
    oe_n = 1'b1; @(negedge clk);
    oe_n = 1'b0;
    #1 chk("R7 before edge", {31'b0, out_vld}, 32'h0);
    @(negedge clk);
    chk("R7 after edge", {31'b0, out_vld}, 32'h1);

    // table: R3, R4, R5, R6
    foreach (VEC[i]) begin
      dvd_in = VEC[i][81:50]; dvs_in = VEC[i][49:34];
      dvd_ld_n = 1'b0; dvs_ld_n = 1'b0;
      @(negedge clk);
      dvd_ld_n = 1'b1; dvs_ld_n = 1'b1;
      repeat (LAT) @(negedge clk);
      if (!VEC[i][1]) chk("R3/R4 table quotient", quo, VEC[i][33:2]);
      chk("R6 table dz", {31'b0, dz}, {31'b0, VEC[i][1]});
      chk("R5 table inexact", {31'b0, inexact}, {31'b0, VEC[i][0]});
    end

    // R1: held divisor, new dividend, divisor input changes without load
    dvd_in = 32'd100; dvs_in = 16'd7; dvd_ld_n = 1'b0; dvs_ld_n = 1'b0;
    @(negedge clk);
    dvs_ld_n = 1'b1; dvs_in = 16'd3; dvd_in = 32'd50;
    @(negedge clk);
    dvd_ld_n = 1'b1; dvd_in = 32'd999;
    repeat (LAT) @(negedge clk);
    chk("R1 held divisor", quo, 32'd7);

    // R7: disabling zeroes outputs
    oe_n = 1'b1; @(negedge clk);
    chk("R7 disabled quo", quo, 32'h0);
    oe_n = 1'b0;

    // R2: back-to-back random traffic, checked by the scoreboard
    for (int c = 0; c < 600; c++) begin
      dvd_in = ($urandom % 16 == 0) ? 32'h80000000 : $urandom;
      case ($urandom % 8)
        0: dvs_in = 16'h0000;
        1: dvs_in = 16'hFFFF;
        2: dvs_in = 16'h8000;
        default: dvs_in = 16'($urandom);
      endcase
      dvd_ld_n = ($urandom % 4 == 0);
      dvs_ld_n = ($urandom % 3 == 0);
      oe_n = ($urandom % 8 == 0);
      @(negedge clk);
    end
    dvd_ld_n = 1'b1; dvs_ld_n = 1'b1; oe_n = 1'b0;
    repeat (LAT + 3) @(negedge clk);
    finish_run();
  end
endmodule